// File: doc/BRIEF.md
# Counter Bank Control and Status Registers

This block is the register layer that sits beside a bank of eight counter/timer channels. Each channel reports the moment its count wraps through a one-cycle terminal-event strobe. The block remembers that event in a sticky per-channel status bit. It turns the bit into the channel's output pin, with an active level chosen per channel. It also raises a single interrupt request when any channel that software has enabled holds a pending event. The counters themselves live elsewhere.

Software reaches the block through a plain 8-bit port: a 4-bit address, a write strobe, write data and combinational read data. Beside the status, interrupt-enable and polarity registers, the block holds gate and direction override bits. Each override bit is ORed with the matching pin level to form the effective gate and direction handed to the counters. Read-only addresses show the live levels of the output, clock, gate and direction pins as the logic itself sees them. The clock, gate and direction pins pass through a two-stage synchronizer first.

Top module: `ctbank_csr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 0, `irq` is 0 and `ch_out` is all ones, which is the inactive level of an active-low output.
- R2: A 1 on `evt_strobe[i]` sets status bit i at the next clock edge. The bit stays set until software clears it. Status is at address 0x0, with bit i for channel i.
- R3: Writing to address 0x0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R4: If an event strobe and a write-1 clear hit the same channel in the same cycle, the status bit ends up set.
- R5: `ch_out[i]` equals status bit i XOR the inverse of polarity bit i. A polarity bit of 1 gives an active-high output and a polarity bit of 0 gives an active-low output.
- R6: The polarity register at address 0x2 is write-only, and reading address 0x2 always returns 0.
- R7: `irq` is 1 exactly when some channel has both its status bit and its interrupt-enable bit set. The interrupt-enable register is read/write at address 0x1.
- R8: The gate override register (address 0x3) and the direction override register (address 0x4) are read/write. `gate_eff` is the synchronized gate pins ORed with the gate override. `dir_eff` is the synchronized direction pins ORed with the direction override.
- R9: Addresses 0x5, 0x6, 0x7 and 0x8 read, in that order, the driven output pins, the clock pins, the gate pins and the direction pins. The three input views lag their pins by two clock edges. Writes to these addresses change nothing.
- R10: Addresses 0x9 to 0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe, one write per cycle it is high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| evt_strobe | input | 8 | Per-channel terminal-event strobes |
| pin_clk_in | input | 8 | Channel clock pin levels |
| pin_gate_in | input | 8 | Channel gate pin levels |
| pin_dir_in | input | 8 | Channel direction pin levels |
| ch_out | output | 8 | Channel output pins |
| gate_eff | output | 8 | Effective gate per channel |
| dir_eff | output | 8 | Effective direction per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a write-1 clear and a terminal event striking the same channel in the same cycle, because the two come from unrelated sources. The stimulus table has a step that drives a status write of 1 and the matching event strobe together, then reads status back at the following cycle. The bench also covers the synchronizer lag: it changes the gate pins and reads their view once after one edge, expecting the old level, and again after two edges.

// File: rtl/ctb_pkg.sv
// Package: shared address map for the counter bank register block.
// Assumes a 4-bit register address; unlisted addresses read as zero.
package ctb_pkg;

    localparam int CTB_AW = 4;

    typedef enum logic [CTB_AW-1:0] {
        CTB_STAT    = 4'h0,
        CTB_IEN     = 4'h1,
        CTB_POL     = 4'h2,
        CTB_GOVR    = 4'h3,
        CTB_DOVR    = 4'h4,
        CTB_OUTPIN  = 4'h5,
        CTB_CLKPIN  = 4'h6,
        CTB_GATEPIN = 4'h7,
        CTB_DIRPIN  = 4'h8
    } ctb_addr_e;

endpackage

// File: rtl/ctb_sync.sv
// Module: ctb_sync
// Multi-stage flip-flop synchronizer for a vector of slow pin levels.
// Assumes each bit is independent (no multi-bit coherence is needed).
module ctb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pin level into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Shift the level one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ctb_status.sv
// Module: ctb_status
// One sticky status flop per channel: a set strobe makes it 1, a clear
// request makes it 0. When both arrive together the set takes priority.
// Assumes set and clear are synchronous to clk.
module ctb_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic bit_q;

        // Keep the channel's pending-event flag, with set over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_i[g])   bit_q <= 1'b1;
            else if (clr_i[g])   bit_q <= 1'b0;
        end

        assign stat_o[g] = bit_q;
    end

endmodule

// File: rtl/ctb_regfile.sv
// Module: ctb_regfile
// Software-writable control registers (interrupt enable, output polarity,
// gate and direction overrides) and the read-data multiplexer.
// Assumes the status register itself is held outside; it is only read here.
module ctb_regfile
    import ctb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTB_AW-1:0] addr,
    input  logic              wr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      stat_lvl,
    input  logic [N-1:0]      out_lvl,
    input  logic [N-1:0]      clk_lvl,
    input  logic [N-1:0]      gate_lvl,
    input  logic [N-1:0]      dir_lvl,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      ien_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      govr_q,
    output logic [N-1:0]      dovr_q
);

    logic wr_ien, wr_pol, wr_govr, wr_dovr;

    // Decode which writable register the current write targets.
    always_comb begin
        wr_ien  = wr && (addr == CTB_IEN);
        wr_pol  = wr && (addr == CTB_POL);
        wr_govr = wr && (addr == CTB_GOVR);
        wr_dovr = wr && (addr == CTB_DOVR);
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wdata;
    end

    // Output polarity register (write-only from software).
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_q <= '0;
        else if (wr_pol) pol_q <= wdata;
    end

    // Gate override register.
    always_ff @(posedge clk) begin
        if (!rst_n)       govr_q <= '0;
        else if (wr_govr) govr_q <= wdata;
    end

    // Direction override register.
    always_ff @(posedge clk) begin
        if (!rst_n)       dovr_q <= '0;
        else if (wr_dovr) dovr_q <= wdata;
    end

    // Select read data by address; polarity and unmapped addresses give 0.
    always_comb begin
        case (addr)
            CTB_STAT:    rdata = stat_lvl;
            CTB_IEN:     rdata = ien_q;
            CTB_GOVR:    rdata = govr_q;
            CTB_DOVR:    rdata = dovr_q;
            CTB_OUTPIN:  rdata = out_lvl;
            CTB_CLKPIN:  rdata = clk_lvl;
            CTB_GATEPIN: rdata = gate_lvl;
            CTB_DIRPIN:  rdata = dir_lvl;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ctbank_csr.sv
// Module: ctbank_csr
// Control and status registers for a bank of counter/timer channels:
// sticky write-1-to-clear status, polarity-controlled output pins,
// a combined interrupt, gate/direction overrides and pin-level views.
// Assumes event strobes are one clk cycle wide and synchronous to clk;
// clock, gate and direction pins may be asynchronous and are synchronized.
module ctbank_csr
    import ctb_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTB_AW-1:0] host_addr,
    input  logic              host_wr,
    input  logic [NCH-1:0]    host_wdata,
    output logic [NCH-1:0]    host_rdata,
    input  logic [NCH-1:0]    evt_strobe,
    input  logic [NCH-1:0]    pin_clk_in,
    input  logic [NCH-1:0]    pin_gate_in,
    input  logic [NCH-1:0]    pin_dir_in,
    output logic [NCH-1:0]    ch_out,
    output logic [NCH-1:0]    gate_eff,
    output logic [NCH-1:0]    dir_eff,
    output logic              irq
);

    localparam int SYNC_W = 3 * NCH;

    logic [NCH-1:0]    status_q;
    logic [NCH-1:0]    stat_clr;
    logic [NCH-1:0]    ien_q, pol_q, govr_q, dovr_q;
    logic [NCH-1:0]    clk_s, gate_s, dir_s;
    logic [SYNC_W-1:0] sync_q;

    // Form the per-channel clear request from a write to the status address.
    always_comb begin
        stat_clr = (host_wr && (host_addr == CTB_STAT)) ? host_wdata : '0;
    end

    ctb_status #(.N(NCH)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_strobe),
        .clr_i  (stat_clr),
        .stat_o (status_q)
    );

    ctb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_dir_in, pin_gate_in, pin_clk_in}),
        .q     (sync_q)
    );

    assign clk_s  = sync_q[NCH-1:0];
    assign gate_s = sync_q[2*NCH-1:NCH];
    assign dir_s  = sync_q[3*NCH-1:2*NCH];

    ctb_regfile #(.N(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (host_addr),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .stat_lvl (status_q),
        .out_lvl  (ch_out),
        .clk_lvl  (clk_s),
        .gate_lvl (gate_s),
        .dir_lvl  (dir_s),
        .rdata    (host_rdata),
        .ien_q    (ien_q),
        .pol_q    (pol_q),
        .govr_q   (govr_q),
        .dovr_q   (dovr_q)
    );

    // Drive output pins, effective gate/direction and the interrupt.
    always_comb begin
        ch_out   = status_q ^ ~pol_q;
        gate_eff = gate_s | govr_q;
        dir_eff  = dir_s | dovr_q;
        irq      = |(status_q & ien_q);
    end

endmodule

// File: rtl/ctbank_csr_chk.sv
// Module: ctbank_csr_chk
// Property checker for ctbank_csr, attached with bind below.
module ctbank_csr_chk
    import ctb_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTB_AW-1:0] host_addr,
    input logic              host_wr,
    input logic [NCH-1:0]    host_wdata,
    input logic [NCH-1:0]    host_rdata,
    input logic [NCH-1:0]    evt_strobe,
    input logic [NCH-1:0]    status_q,
    input logic [NCH-1:0]    ien_q,
    input logic              irq
);

    // R2: a strobed channel shows a set status bit one edge later.
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_strobe != '0) |=> ((status_q & $past(evt_strobe)) == $past(evt_strobe)));

    // R3 and R4: bits written 1 and not strobed are clear afterwards.
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == CTB_STAT)
        |=> ((status_q & $past(host_wdata & ~evt_strobe)) == '0));

    // R3: with no event and no status write, status holds.
    p_status_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr && host_addr == CTB_STAT) && evt_strobe == '0)
        |=> (status_q == $past(status_q)));

    // R7: an event on an enabled channel raises the interrupt next cycle.
    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((evt_strobe & ien_q) != '0) && !(host_wr && host_addr == CTB_IEN))
        |=> irq);

    // R6: the write-only polarity address reads zero.
    p_pol_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == CTB_POL) |-> (host_rdata == '0));

    // R10: unmapped addresses read zero.
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr > CTB_DIRPIN) |-> (host_rdata == '0));

endmodule

bind ctbank_csr ctbank_csr_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .evt_strobe (evt_strobe),
    .status_q   (status_q),
    .ien_q      (ien_q),
    .irq        (irq)
);

// File: tb/ctbank_csr_tb.sv
module ctbank_csr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] evt_strobe = '0;
    logic [7:0] pin_clk_in = '0;
    logic [7:0] pin_gate_in = '0;
    logic [7:0] pin_dir_in = '0;
    logic [7:0] ch_out, gate_eff, dir_eff;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ctbank_csr dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_strobe(evt_strobe),
        .pin_clk_in(pin_clk_in), .pin_gate_in(pin_gate_in), .pin_dir_in(pin_dir_in),
        .ch_out(ch_out), .gate_eff(gate_eff), .dir_eff(dir_eff), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] waddr;
        logic [7:0] wdata;
        logic [7:0] evt;
        logic [3:0] raddr;
        logic [7:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h1, 8'h0F, 8'h00, 4'h1, 8'h0F, 1'b0}, // R7 enable write/readback
        '{1'b0, 4'h0, 8'h00, 8'h05, 4'h0, 8'h05, 1'b1}, // R2 events set, R7 irq
        '{1'b1, 4'h0, 8'h01, 8'h00, 4'h0, 8'h04, 1'b1}, // R3 clear one bit
        '{1'b1, 4'h0, 8'h00, 8'h00, 4'h0, 8'h04, 1'b1}, // R3 zero write no effect
        '{1'b1, 4'h0, 8'h04, 8'h04, 4'h0, 8'h04, 1'b1}, // R4 set wins
        '{1'b1, 4'h0, 8'h04, 8'h00, 4'h0, 8'h00, 1'b0}, // R3 clear, R7 irq drops
        '{1'b0, 4'h0, 8'h00, 8'h80, 4'h0, 8'h80, 1'b0}, // R2 set, R7 not enabled
        '{1'b1, 4'h1, 8'h80, 8'h00, 4'h1, 8'h80, 1'b1}, // R7 enable raises irq
        '{1'b1, 4'h2, 8'hFF, 8'h00, 4'h2, 8'h00, 1'b1}, // R6 polarity reads zero
        '{1'b0, 4'h0, 8'h00, 8'h00, 4'h5, 8'h80, 1'b1}, // R5 active-high output
        '{1'b1, 4'h2, 8'h00, 8'h00, 4'h5, 8'h7F, 1'b1}, // R5 active-low output
        '{1'b1, 4'h3, 8'hA5, 8'h00, 4'h3, 8'hA5, 1'b1}, // R8 gate override
        '{1'b1, 4'h4, 8'h3C, 8'h00, 4'h4, 8'h3C, 1'b1}, // R8 direction override
        '{1'b1, 4'h5, 8'hFF, 8'h00, 4'h5, 8'h7F, 1'b1}, // R9 read-only write ignored
        '{1'b1, 4'hF, 8'hFF, 8'h00, 4'hF, 8'h00, 1'b1}, // R10 unmapped reads zero
        '{1'b1, 4'h0, 8'hFF, 8'h00, 4'h0, 8'h00, 1'b0}  // R3 clear all
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input string req, input logic [7:0] exp);
        host_wr   = 1'b0;
        host_addr = a;
        #1;
        chk(req, host_rdata, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 ch_out", ch_out, 8'hFF);
        chk("R1 irq", irq, 1'b0);
        chk("R1 gate_eff", gate_eff, 8'h00);
        for (int a = 0; a < 9; a++) begin
            rd(a[3:0], "R1 register", (a == 5) ? 8'hFF : 8'h00);
        end

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_wr    = VECS[i].wr;
            host_addr  = VECS[i].waddr;
            host_wdata = VECS[i].wdata;
            evt_strobe = VECS[i].evt;
            @(negedge clk);
            evt_strobe = '0;
            rd(VECS[i].raddr, $sformatf("vector %0d rdata", i), VECS[i].exp_rd);
            chk($sformatf("vector %0d irq", i), irq, VECS[i].exp_irq);
        end
        // R5 pin state after clearing all with polarity 0: inactive high
        chk("R5 ch_out inactive", ch_out, 8'hFF);

        // R9 synchronizer lag on gate view, R8 effective gate
        @(negedge clk);
        pin_gate_in = 8'h5A;
        pin_clk_in  = 8'hC3;
        pin_dir_in  = 8'h01;
        @(negedge clk);
        rd(4'h7, "R9 gate view after one edge", 8'h00);
        @(negedge clk);
        rd(4'h7, "R9 gate view after two edges", 8'h5A);
        rd(4'h6, "R9 clock view", 8'hC3);
        rd(4'h8, "R9 direction view", 8'h01);
        chk("R8 gate_eff", gate_eff, 8'hFF);
        chk("R8 dir_eff", dir_eff, 8'h3D);

        // R1 reset in mid-operation
        @(negedge clk);
        evt_strobe = 8'h0F;
        @(negedge clk);
        evt_strobe = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'h0, "R1 status after reset", 8'h00);
        rd(4'h3, "R1 gate override after reset", 8'h00);
        chk("R1 irq after reset", irq, 1'b0);

        finish_run();
    end

endmodule